// File: doc/BRIEF.md
# Configurable Two-Table Logic Cell

This block models one programmable logic cell. It holds two independent lookup tables with four inputs each, called F and G. A third, smaller table, H, with three inputs, takes the F result, the G result and one external input. With H, the cell can produce functions that depend on up to nine input signals. Two outputs each pick one of four sources through configuration. Each output then either passes that source straight through or takes it from its own storage flip-flop. Both flip-flops share clock enable, set and reset pins. Configuration decides whether set and reset act synchronously or asynchronously, and whether the enable, set and reset pins are active-high or active-low.

All truth tables and mode bits form one 53-bit image. The image is shifted in one bit per clock while the load enable is high. Until a complete image has been taken in and the load enable has dropped again, both outputs are forced low and both flip-flops are kept cleared.

Top module: `logic_cell_2lut`

## Requirements
- R1: The F output equals image bit `f_in` of field [15:0]. The G output equals image bit `g_in` of field [31:16], where the 4-bit input value is the table index.
- R2: The H output equals bit {h1_in, G, F} of field [39:32]. h1_in is the index MSB and F is the index LSB.
- R3: Each output has a 5-bit field, at [47:43] for out_a and [52:48] for out_b. Its two low bits select the source: 0 = F, 1 = G, 2 = H, 3 = h1_in. The remaining bits, from low to high, are use_reg, set_async and rst_async.
- R4: With use_reg = 0 an output follows its source in the same cycle. With use_reg = 1 it shows the flip-flop, which takes the source value at a rising clock edge.
- R5: The image is shifted in with its MSB first, one bit per clock while cfg_en is high. After reset, and while loading, both outputs are 0. Outputs become valid after the first clock edge that sees cfg_en low, provided at least 53 bits were shifted.
- R6: When the effective clock enable is inactive, a flip-flop holds its value. Image bit 40 inverts the ce pin.
- R7: A synchronous reset clears a flip-flop at the next edge and a synchronous set sets it. Reset wins over set and over the enable. Bits 41 and 42 invert the set_in and rst_in pins.
- R8: When the configuration marks set or reset as asynchronous, the flip-flop changes without a clock edge. Reset still wins over set.
- R9: A new load with cfg_en high forces the outputs to 0. A load of fewer than 53 bits leaves the cell unconfigured with outputs 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, clears configuration and flip-flops |
| cfg_en | input | 1 | Configuration shift enable |
| cfg_bit | input | 1 | Serial configuration data, MSB first |
| f_in | input | 4 | Index into the F table |
| g_in | input | 4 | Index into the G table |
| h1_in | input | 1 | Extra input to H, also directly selectable |
| ce | input | 1 | Flip-flop clock enable, polarity configurable |
| set_in | input | 1 | Flip-flop set, polarity and timing configurable |
| rst_in | input | 1 | Flip-flop reset, polarity and timing configurable |
| out_a | output | 1 | Cell output A |
| out_b | output | 1 | Cell output B |

## Verification
A bit of the shift image that lands in the wrong place changes the truth table or the mode. On a combinational output this shows in the same cycle as the input pattern that addresses the bad entry. A flip-flop that loses or gains a value shows one edge later on a registered output. A wrong async/sync choice shows within the same half cycle, because the output changes before the next edge when it should not, or fails to change when it should. A bad load counter shows as outputs that stay at zero, or that come alive after a short load.

// File: rtl/lcell_pkg.sv
package lcell_pkg;
    localparam int LUT_K = 4;
    localparam int TAB_W = 1 << LUT_K;
    localparam int H_K   = 3;
    localparam int H_W   = 1 << H_K;
    localparam int N_OUT = 2;

    typedef enum logic [1:0] {
        SRC_F  = 2'd0,
        SRC_G  = 2'd1,
        SRC_H  = 2'd2,
        SRC_X  = 2'd3
    } src_e;

    typedef struct packed {
        logic rst_async;
        logic set_async;
        logic use_reg;
        src_e src;
    } out_cfg_t;

    typedef struct packed {
        out_cfg_t [N_OUT-1:0] outc;
        logic                 rst_inv;
        logic                 set_inv;
        logic                 ce_inv;
        logic [H_W-1:0]       h_tab;
        logic [TAB_W-1:0]     g_tab;
        logic [TAB_W-1:0]     f_tab;
    } cell_cfg_t;

    localparam int CFG_W = $bits(cell_cfg_t);
endpackage

// File: rtl/lcell_lut.sv
module lcell_lut #(
    parameter int K = 4
) (
    input  logic [(1<<K)-1:0] tab,
    input  logic [K-1:0]      sel,
    output logic              o
);
    localparam int N = 1 << K;

    // binary mux tree, one level per select bit: depth fixed by K, not by the function
    logic [2*N-2:0] node;
    assign node[N-1 +: N] = tab;
    for (genvar lv = 0; lv < K; lv++) begin : g_lvl
        localparam int W    = 1 << lv;
        localparam int BASE = W - 1;
        for (genvar i = 0; i < W; i++) begin : g_node
            assign node[BASE + i] = sel[K-1-lv] ? node[2*(BASE+i)+2] : node[2*(BASE+i)+1];
        end
    end
    // node index follows heap order; reorder table so leaf order matches sel
    assign o = node[0];
endmodule

// File: rtl/lcell_loader.sv
module lcell_loader #(
    parameter int IMG_W = 53
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en,
    input  logic             cfg_bit,
    output logic [IMG_W-1:0] img,
    output logic             ready
);
    localparam int CNT_W = $clog2(IMG_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(IMG_W);

    typedef struct packed {
        logic [IMG_W-1:0] img;
        logic [CNT_W-1:0] cnt;
        logic             en;
        logic             ready;
    } ld_t;

    ld_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.en    = cfg_en;
        st_d.ready = 1'b0;
        if (cfg_en) begin
            st_d.img = {st_q.img[IMG_W-2:0], cfg_bit};
            if (!st_q.en)
                st_d.cnt = CNT_W'(1);
            else if (st_q.cnt != FULL)
                st_d.cnt = st_q.cnt + CNT_W'(1);
        end else begin
            st_d.ready = (st_q.cnt == FULL);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign img   = st_q.img;
    assign ready = st_q.ready;

    p_load_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |=> !ready);
    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= FULL);
    p_short_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_en && st_q.cnt != FULL) |=> !ready);
endmodule

// File: rtl/lcell_store.sv
module lcell_store (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic d,
    input  logic ce,
    input  logic s_sync,
    input  logic r_sync,
    input  logic s_async,
    input  logic r_async,
    output logic q
);
    logic q_d, q_q;

    always_comb begin
        if (clr)         q_d = 1'b0;
        else if (r_sync) q_d = 1'b0;
        else if (s_sync) q_d = 1'b1;
        else if (ce)     q_d = d;
        else             q_d = q_q;
    end

    always_ff @(posedge clk or negedge rst_n or posedge r_async or posedge s_async) begin
        if (!rst_n)       q_q <= 1'b0;
        else if (r_async) q_q <= 1'b0;
        else if (s_async) q_q <= 1'b1;
        else              q_q <= q_d;
    end

    assign q = q_q;

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !ce && !r_sync && !s_sync && !r_async && !s_async)
        |=> ($stable(q) || r_async || s_async));
    p_sync_rst_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_sync && !s_async) |=> !q);
    p_async_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_async && !r_async) |-> q);
    p_async_rst_r8: assert property (@(posedge clk) disable iff (!rst_n)
        r_async |-> !q);
endmodule

// File: rtl/logic_cell_2lut.sv
module logic_cell_2lut
    import lcell_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_en,
    input  logic        cfg_bit,
    input  logic [3:0]  f_in,
    input  logic [3:0]  g_in,
    input  logic        h1_in,
    input  logic        ce,
    input  logic        set_in,
    input  logic        rst_in,
    output logic        out_a,
    output logic        out_b
);
    logic [CFG_W-1:0] img;
    logic             ready;
    cell_cfg_t        cfg;

    lcell_loader #(.IMG_W(CFG_W)) u_ld (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_en  (cfg_en),
        .cfg_bit (cfg_bit),
        .img     (img),
        .ready   (ready)
    );

    assign cfg = cell_cfg_t'(img);

    logic f_o, g_o, h_o;
    logic [TAB_W-1:0] f_heap, g_heap;
    logic [H_W-1:0]   h_heap;

    // the mux tree reads select MSB first; bit-reverse nothing, tables are indexed directly
    assign f_heap = f_tab_order(cfg.f_tab);
    assign g_heap = f_tab_order(cfg.g_tab);
    assign h_heap = h_tab_order(cfg.h_tab);

    function automatic logic [TAB_W-1:0] f_tab_order(input logic [TAB_W-1:0] t);
        f_tab_order = t;
    endfunction
    function automatic logic [H_W-1:0] h_tab_order(input logic [H_W-1:0] t);
        h_tab_order = t;
    endfunction

    lcell_lut #(.K(LUT_K)) u_f (.tab(f_heap), .sel(f_in), .o(f_o));
    lcell_lut #(.K(LUT_K)) u_g (.tab(g_heap), .sel(g_in), .o(g_o));
    lcell_lut #(.K(H_K))   u_h (.tab(h_heap), .sel({h1_in, g_o, f_o}), .o(h_o));

    logic ce_act, set_act, rst_act;
    assign ce_act  = ce     ^ cfg.ce_inv;
    assign set_act = set_in ^ cfg.set_inv;
    assign rst_act = rst_in ^ cfg.rst_inv;

    logic [N_OUT-1:0] y;

    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        logic src_v, q;
        logic s_as, r_as, s_sy, r_sy;

        always_comb begin
            unique case (cfg.outc[o].src)
                SRC_F:   src_v = f_o;
                SRC_G:   src_v = g_o;
                SRC_H:   src_v = h_o;
                default: src_v = h1_in;
            endcase
        end

        assign r_as = ready &  rst_act &  cfg.outc[o].rst_async;
        assign s_as = ready &  set_act &  cfg.outc[o].set_async;
        assign r_sy = rst_act & ~cfg.outc[o].rst_async;
        assign s_sy = set_act & ~cfg.outc[o].set_async;

        lcell_store u_st (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (~ready),
            .d       (src_v),
            .ce      (ce_act),
            .s_sync  (s_sy),
            .r_sync  (r_sy),
            .s_async (s_as),
            .r_async (r_as),
            .q       (q)
        );

        assign y[o] = ready & (cfg.outc[o].use_reg ? q : src_v);
    end

    assign out_a = y[0];
    assign out_b = y[1];

    p_idle_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> (out_a == 1'b0 && out_b == 1'b0));
    p_reload_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |=> (out_a == 1'b0 && out_b == 1'b0));
endmodule

// File: tb/test_logic_cell_2lut.sv
`timescale 1ns/1ps
module test_logic_cell_2lut;
    localparam int IW = 53;

    logic clk = 1'b0;
    logic rst_n, cfg_en, cfg_bit, h1_in, ce, set_in, rst_in;
    logic [3:0] f_in, g_in;
    logic out_a, out_b;
    int n_cmp = 0, n_err = 0;
    bit done = 0;

    always #10 clk = ~clk;

    logic_cell_2lut i_logic_cell_2lut (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_bit(cfg_bit),
        .f_in(f_in), .g_in(g_in), .h1_in(h1_in), .ce(ce),
        .set_in(set_in), .rst_in(rst_in), .out_a(out_a), .out_b(out_b)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: got %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    endtask

    // out field = {rst_async, set_async, use_reg, src[1:0]}; inv = {rst_inv, set_inv, ce_inv}
    function automatic logic [IW-1:0] mk_img(input logic [15:0] f, input logic [15:0] g,
                                             input logic [7:0] h, input logic [2:0] inv,
                                             input logic [4:0] oa, input logic [4:0] ob);
        return {ob, oa, inv, h, g, f};
    endfunction

    function automatic logic pick(input logic [4:0] src, input logic [15:0] f, input logic [15:0] g,
                                  input logic [7:0] h, input logic [3:0] fi, input logic [3:0] gi,
                                  input logic x);
        logic fo, go;
        fo = f[fi];
        go = g[gi];
        case (src[1:0])
            2'd0: return fo;
            2'd1: return go;
            2'd2: return h[{x, go, fo}];
            default: return x;
        endcase
    endfunction

    task automatic load(input logic [IW-1:0] im, input int nbits);
        @(negedge clk);
        cfg_en = 1'b1;
        for (int i = IW-1; i > IW-1-nbits; i--) begin
            cfg_bit = im[i];
            @(negedge clk);
            if (i == IW-20) begin
                chk("R5", "out_a during load", out_a, 1'b0);
                chk("R9", "out_b during load", out_b, 1'b0);
            end
        end
        cfg_en = 1'b0;
        @(negedge clk);
    endtask

    logic [15:0] tf, tg;
    logic [7:0]  th;

    // registered loop: out_a = F registered sync, out_b = G comb
    task automatic run_reg(input int n, input logic [2:0] inv);
        logic eq, nq, ce_a, s_a, r_a;
        tf = 16'($urandom); tg = 16'($urandom); th = 8'($urandom);
        ce = inv[0]; set_in = inv[1]; rst_in = inv[2];
        load(mk_img(tf, tg, th, inv, 5'b00100, 5'b00001), IW);
        eq = 1'b0;
        for (int k = 0; k < n; k++) begin
            chk("R4", "registered out_a after edge", out_a, eq);
            f_in = 4'($urandom); g_in = 4'($urandom);
            ce_a = 1'($urandom);
            s_a  = ($urandom % 8) == 0;
            r_a  = ($urandom % 8) == 0;
            ce = ce_a ^ inv[0]; set_in = s_a ^ inv[1]; rst_in = r_a ^ inv[2];
            #2;
            chk("R4", "comb out_b same cycle", out_b, tg[g_in]);
            chk("R4", "registered out_a before edge", out_a, eq);
            nq = r_a ? 1'b0 : s_a ? 1'b1 : ce_a ? tf[f_in] : eq;
            @(negedge clk);
            eq = nq;
        end
        chk("R6 R7", "final registered value", out_a, eq);
        ce = inv[0]; set_in = inv[1]; rst_in = inv[2];
    endtask

    logic [15:0] ex_f, ex_g;
    logic [7:0]  ex_h;

    initial begin
        void'($urandom(32'd2024));
        rst_n = 1'b0; cfg_en = 1'b0; cfg_bit = 1'b0; f_in = '0; g_in = '0;
        h1_in = 1'b0; ce = 1'b0; set_in = 1'b0; rst_in = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        f_in = 4'b0100; g_in = 4'hF; h1_in = 1'b1;
        #2;
        chk("R5", "out_a after reset", out_a, 1'b0);
        chk("R5", "out_b after reset", out_b, 1'b0);
        repeat (3) @(negedge clk);
        chk("R5", "out_a unconfigured", out_a, 1'b0);

        // example: X = A'B'(C+D) on F, AEJL on G, Y = K F' + G on H
        for (int i = 0; i < 16; i++) begin
            ex_f[i] = ~i[0] & ~i[1] & (i[2] | i[3]);
            ex_g[i] = (i == 15);
        end
        for (int i = 0; i < 8; i++) ex_h[i] = (i[2] & ~i[0]) | i[1];
        load(mk_img(ex_f, ex_g, ex_h, 3'b000, 5'b00000, 5'b00010), IW);
        for (int v = 0; v < 256; v++) begin
            logic a, b, c, d, e, j, kk, l, x, y;
            {a, b, c, d, e, j, kk, l} = 8'(v);
            f_in = {d, c, b, a}; g_in = {l, j, e, a}; h1_in = kk;
            #2;
            x = ~a & ~b & (c | d);
            y = (kk & ~x) | (a & e & j & l);
            chk("R1", "X on F", out_a, x);
            chk("R2", "Y on H", out_b, y);
            #1;
        end

        // random tables, all source selections, combinational
        for (int s = 0; s < 4; s++) begin
            tf = 16'($urandom); tg = 16'($urandom); th = 8'($urandom);
            load(mk_img(tf, tg, th, 3'b000, 5'(s), 5'(3 - s)), IW);
            for (int k = 0; k < 40; k++) begin
                f_in = 4'($urandom); g_in = 4'($urandom); h1_in = 1'($urandom);
                #2;
                chk("R3", "out_a source", out_a, pick(5'(s), tf, tg, th, f_in, g_in, h1_in));
                chk("R1 R2 R3", "out_b source", out_b, pick(5'(3 - s), tf, tg, th, f_in, g_in, h1_in));
                #1;
            end
        end

        run_reg(60, 3'b000);   // R4 R6 R7 active-high
        run_reg(60, 3'b111);   // R6 R7 inverted polarity

        // async: out_a F registered sync, out_b G registered async set and reset
        tf = 16'h0000; tg = 16'h0000; th = 8'h00;
        ce = 1'b0; set_in = 1'b0; rst_in = 1'b0;
        load(mk_img(tf, tg, th, 3'b000, 5'b00100, 5'b11101), IW);
        set_in = 1'b1;
        #2;
        chk("R8", "async set without edge", out_b, 1'b1);
        chk("R7", "sync set waits for edge", out_a, 1'b0);
        @(negedge clk);
        chk("R7", "sync set after edge", out_a, 1'b1);
        set_in = 1'b0;
        @(negedge clk);
        chk("R8", "async set holds", out_b, 1'b1);
        rst_in = 1'b1;
        #2;
        chk("R8", "async reset without edge", out_b, 1'b0);
        chk("R7", "sync reset waits for edge", out_a, 1'b1);
        @(negedge clk);
        chk("R7", "sync reset after edge", out_a, 1'b0);
        rst_in = 1'b0;
        @(negedge clk);
        set_in = 1'b1; rst_in = 1'b1;
        #2;
        chk("R8", "async reset beats set", out_b, 1'b0);
        @(negedge clk);
        chk("R7", "sync reset beats set", out_a, 1'b0);
        set_in = 1'b0; rst_in = 1'b0;
        @(negedge clk);

        // short reload leaves cell unconfigured
        load(mk_img(ex_f, ex_g, ex_h, 3'b000, 5'b00000, 5'b00010), IW);
        f_in = 4'b0100; g_in = 4'h0; h1_in = 1'b1;
        #2;
        chk("R1", "X before reload", out_a, 1'b1);
        load(mk_img(ex_f, ex_g, ex_h, 3'b000, 5'b00000, 5'b00010), 25);
        for (int k = 0; k < 3; k++) begin
            chk("R9", "out_a after short load", out_a, 1'b0);
            chk("R9", "out_b after short load", out_b, 1'b0);
            @(negedge clk);
        end
        load(mk_img(ex_f, ex_g, ex_h, 3'b000, 5'b00000, 5'b00010), IW);
        #2;
        chk("R5", "X after full reload", out_a, 1'b1);
        chk("R5", "Y after full reload", out_b, 1'b0);

        done = 1;
        summary();
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: run did not finish");
            summary();
            $finish;
        end
    end
endmodule